// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on an external capture pin. The pin is brought into the system clock domain by a synchroniser and can optionally pass through a noise filter. The block watches for one chosen edge, rising or falling. When that edge arrives, it copies the value of a free-running counter into a capture register, sets a sticky capture flag and, if the capture interrupt is enabled, raises an interrupt request. Software clears the flag with a one-cycle clear strobe. A mode input marks the capture register as the counter's TOP value; while it is set, the pin is ignored and no capture happens.

The noise filter is a four-state machine. Its states are `FLT_LOW` and `FLT_HIGH`, which are the stable levels, and `FLT_RISING` and `FLT_FALLING`, which count candidate samples. Its transitions are as follows:

- `FLT_LOW` goes to `FLT_RISING` when a high sample arrives.
- `FLT_RISING` goes to `FLT_HIGH` after FILT_LEN consecutive high samples.
- `FLT_RISING` returns to `FLT_LOW` on any low sample.
- `FLT_HIGH` goes to `FLT_FALLING` when a low sample arrives.
- `FLT_FALLING` goes to `FLT_LOW` after FILT_LEN consecutive low samples.
- `FLT_FALLING` returns to `FLT_HIGH` on any high sample.

The filtered level is high in `FLT_HIGH` and `FLT_FALLING`. When the filter is disabled, the synchronised pin drives the edge detector directly. The edge detector compares successive samples of its selected source. It never compares against the edge-select input.

Top module: `icap_unit`

## Requirements
- R1: After reset, the capture register is 0x0000 and both the flag and the interrupt request are 0.
- R2: With the filter off, a matching pin change made between clock edges updates the capture register and sets the flag on the 3rd rising clock edge after the change. The stored value is the counter input sampled at that edge. Nothing changes on the edges before it.
- R3: With the filter on, the same update happens on the 7th edge after the change, four edges later than with the filter off.
- R4: With the filter on, a pin level held for only 3 clock cycles before returning produces no capture. A level held for 4 cycles is accepted.
- R5: The edge-select input chooses the trigger: 1 means a rising edge (0 to 1), 0 means a falling edge (1 to 0). The other edge causes no capture.
- R6: Changing the edge-select input while the pin is steady never causes a capture.
- R7: While the capture-as-TOP input is 1, pin edges cause no capture, and the capture register and flag keep their values.
- R8: The flag stays 1 until a clear strobe. A strobe with no capture in the same cycle makes the flag 0 after that edge.
- R9: If a capture and a clear strobe fall on the same edge, the flag ends up 1.
- R10: The interrupt request equals the flag ANDed with the interrupt enable, with no added delay.
- R11: A later capture overwrites the capture register with the newer counter value, even if the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | 16 | Free-running counter value |
| filt_en_i | input | 1 | 1 = noise filter in the path |
| edge_rise_i | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| top_is_cap_i | input | 1 | 1 = capture register serves as TOP; capture disabled |
| irq_en_i | input | 1 | Capture interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_value_o | output | 16 | Capture register |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with its defaults: a 2-stage synchroniser, a filter length of 4 and a 16-bit counter. With these values, the 3-edge and 7-edge capture latencies can be checked exactly, and 3-cycle versus 4-cycle pulses sit on the filter's acceptance boundary. The bench's counter starts just below all-ones, so early captures record values on both sides of the wrap to zero. Random rounds mix filter mode, edge select and interrupt enable against a bench-side latency and value model. Directed cases cover the clear race, steady-pin select changes and the TOP mode.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        FLT_LOW     = 2'd0,
        FLT_RISING  = 2'd1,
        FLT_HIGH    = 2'd2,
        FLT_FALLING = 2'd3
    } flt_state_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    localparam int RW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

    flt_state_e state_q, state_d;
    logic [RW-1:0] run_q, run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            FLT_LOW: begin
                if (din) begin
                    state_d = FLT_RISING;
                    run_d   = RW'(1);
                end
            end
            FLT_RISING: begin
                if (!din) begin
                    state_d = FLT_LOW;
                    run_d   = '0;
                end else if (run_q == RUN_LAST) begin
                    state_d = FLT_HIGH;
                    run_d   = '0;
                end else begin
                    run_d = run_q + RW'(1);
                end
            end
            FLT_HIGH: begin
                if (!din) begin
                    state_d = FLT_FALLING;
                    run_d   = RW'(1);
                end
            end
            FLT_FALLING: begin
                if (din) begin
                    state_d = FLT_HIGH;
                    run_d   = '0;
                end else if (run_q == RUN_LAST) begin
                    state_d = FLT_LOW;
                    run_d   = '0;
                end else begin
                    run_d = run_q + RW'(1);
                end
            end
            default: begin
                state_d = FLT_LOW;
                run_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLT_HIGH, FLT_FALLING: level = 1'b1;
            default:               level = 1'b0;
        endcase
    end

    // the filtered level moves only once a full run of equal samples is seen
    p_filt_full_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(run_q) == RUN_LAST))
        else $error("filtered level changed without a full run");
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic sel_rise,
    output logic evt
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign evt  = sel_rise ? rise : fall;

    // a rising edge cannot repeat on the next cycle; no select-driven events
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("rising edge seen on two successive cycles");
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             filt_en_i,
    input  logic             edge_rise_i,
    input  logic             top_is_cap_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap_value_o,
    output logic             cap_flag_o,
    output logic             irq_o
);
    logic sync_lvl, filt_lvl, src_lvl, raw_evt, fire;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(sync_lvl)
    );

    icap_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .din(sync_lvl), .level(filt_lvl)
    );

    assign src_lvl = filt_en_i ? filt_lvl : sync_lvl;

    icap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .sel_rise(edge_rise_i), .evt(raw_evt)
    );

    assign fire = raw_evt & ~top_is_cap_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_value_o <= '0;
            cap_flag_o  <= 1'b0;
        end else begin
            if (fire) cap_value_o <= count_i;
            if (fire)            cap_flag_o <= 1'b1;
            else if (flag_clr_i) cap_flag_o <= 1'b0;
        end
    end

    assign irq_o = cap_flag_o & irq_en_i;

    p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        top_is_cap_i |=> $stable(cap_value_o))
        else $error("capture register moved in TOP mode");

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !flag_clr_i) |=> cap_flag_o)
        else $error("flag dropped without a clear");

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !fire) |=> !cap_flag_o)
        else $error("clear strobe ignored");

    p_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && fire) |=> cap_flag_o)
        else $error("clear beat a coincident capture");

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_flag_o |-> !irq_o)
        else $error("interrupt without flag");
endmodule

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] cnt = 16'hFFE8;
    logic        filt_en = 1'b0, edge_rise = 1'b1, top_cap = 1'b0, irq_en = 1'b0, clr = 1'b0;
    logic [15:0] cap;
    logic        flag, irq;
    int nchk = 0, nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    icap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(cnt),
        .filt_en_i(filt_en), .edge_rise_i(edge_rise), .top_is_cap_i(top_cap),
        .irq_en_i(irq_en), .flag_clr_i(clr),
        .cap_value_o(cap), .cap_flag_o(flag), .irq_o(irq)
    );

    function automatic int lat(input logic f);
        return f ? 7 : 3;
    endfunction

    function automatic logic [15:0] exp_cap(input logic [15:0] c0, input logic f);
        return c0 + 16'(lat(f) - 1);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    // drive an edge and check the capture timing and value
    task automatic edge_capture(input string req, input logic f);
        logic [15:0] c0;
        clear_flag();
        c0 = cnt;
        pin = ~pin;
        step(lat(f) - 1);
        chk({req, " no early flag"}, flag, 0);
        step(1);
        chk({req, " flag"}, flag, 1);
        chk({req, " value"}, cap, exp_cap(c0, f));
        step(8);
    endtask

    initial begin
        logic [15:0] c0, old;
        void'($urandom(32'd77));
        step(3);
        chk("R1 cap reset", cap, 0);
        chk("R1 flag reset", flag, 0);
        chk("R1 irq reset", irq, 0);
        rst_n = 1'b1;
        step(3);

        // R2 unfiltered rising
        edge_rise = 1'b1; filt_en = 1'b0;
        edge_capture("R2 rise", 1'b0);
        // R5 falling with rising selected: no capture
        clear_flag(); old = cap;
        pin = 1'b0; step(10);
        chk("R5 opposite edge flag", flag, 0);
        chk("R5 opposite edge value", cap, old);
        // R5 falling selected
        edge_rise = 1'b0; pin = 1'b1; step(10);
        edge_capture("R5 fall", 1'b0);

        // R3 filtered latency
        filt_en = 1'b1; edge_rise = 1'b1; step(10);
        edge_capture("R3 filt rise", 1'b1);
        pin = 1'b0; step(12); clear_flag();

        // R4 3-cycle pulse rejected, 4-cycle accepted
        old = cap;
        pin = 1'b1; step(3); pin = 1'b0; step(12);
        chk("R4 short pulse flag", flag, 0);
        chk("R4 short pulse value", cap, old);
        c0 = cnt;
        pin = 1'b1; step(4); pin = 1'b0; step(3);
        chk("R4 long pulse flag", flag, 1);
        chk("R4 long pulse value", cap, exp_cap(c0, 1'b1));
        step(10); clear_flag();

        // R6 select toggling with steady pin
        filt_en = 1'b0; step(4);
        for (int i = 0; i < 6; i++) begin
            edge_rise = ~edge_rise; step(2);
        end
        chk("R6 select change flag", flag, 0);

        // R7 TOP mode blocks capture
        edge_rise = 1'b1; top_cap = 1'b1; old = cap;
        pin = 1'b1; step(10); pin = 1'b0; step(10);
        chk("R7 top flag", flag, 0);
        chk("R7 top value", cap, old);
        top_cap = 1'b0; step(4);

        // R8 sticky and R11 overwrite
        c0 = cnt; pin = 1'b1; step(12);
        chk("R8 sticky", flag, 1);
        pin = 1'b0; step(6);
        c0 = cnt; pin = 1'b1; step(3);
        chk("R11 overwrite", cap, exp_cap(c0, 1'b0));
        irq_en = 1'b1; #1;
        chk("R10 irq on", irq, 1);
        irq_en = 1'b0; #1;
        chk("R10 irq masked", irq, 0);
        step(1); clear_flag();
        chk("R8 cleared", flag, 0);

        // R9 clear coincides with capture
        pin = 1'b0; step(8);
        pin = 1'b1; step(2); clr = 1'b1; step(1); clr = 1'b0;
        chk("R9 race flag", flag, 1);
        step(4);

        // random rounds
        for (int r = 0; r < 40; r++) begin
            logic f, s, e, hit;
            f = 1'($urandom % 2); s = 1'($urandom % 2); e = 1'($urandom % 2);
            filt_en = f; edge_rise = s; irq_en = e;
            step(2); clear_flag(); old = cap;
            hit = (s == ~pin);
            c0 = cnt; pin = ~pin;
            step(lat(f) - 1);
            chk("R2/R3 random early", flag, 0);
            step(1);
            chk("R5 random flag", flag, hit);
            chk("R11 random value", cap, hit ? exp_cap(c0, f) : old);
            chk("R10 random irq", irq, hit & e);
            step(6);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule